// File: doc/BRIEF.md
# Configuration stream sync hunter and word packer

This block sits at the front of a configuration loader. Bytes arrive one per cycle while `in_valid` is high. Until it locks, the block watches the most recent four accepted bytes for the synchronisation value 0xAA995566. That value is sent as the bytes AA, 99, 55 and 66, in that order. Arbitrary padding may come before the value, and the value may start at any byte position. Nothing seen before lock is passed on, and neither are the four pattern bytes.

Once locked, the block stops hunting. It packs every later accepted byte into 32-bit big-endian words, so word alignment follows from where the pattern ended. Each finished word appears on `word_data` with a one-cycle `word_valid` strobe.

The final byte of a stream is marked with `in_last`. If the stream ends before lock, the block raises a sticky no-sync error. If it ends after lock part-way through a word, the partial word is discarded and a sticky truncation flag is raised. After the end of a stream, all input is ignored until reset.

Top module: `cfg_sync_packer`

## Requirements
- R1: After a synchronous reset, `sync_found`, `word_valid`, `no_sync_err` and `trunc_err` are 0 and `word_data` is 0.
- R2: When the bytes AA, 99, 55, 66 are accepted on four consecutive valid cycles, `sync_found` goes high in the cycle after the 66 byte is sampled. This holds at any byte offset, and idle cycles may fall between the pattern bytes. `sync_found` then stays high until reset.
- R3: Matching always uses the last four accepted bytes. A partial match that breaks off, or an overlapping prefix such as AA AA 99 55 66 or AA 99 AA 99 55 66, still detects the pattern that completes. A padding run such as FF FF FF FF 00 00 00 BB 11 22 00 44 never matches.
- R4: No word is emitted from bytes before the pattern or from the pattern bytes themselves. `word_valid` is never high while `sync_found` is low.
- R5: Words are big-endian. The first byte accepted after the pattern lands in `word_data[31:24]` and the fourth in `word_data[7:0]`.
- R6: `word_valid` is high for exactly one cycle, in the cycle after the fourth byte of a word is sampled. `word_data` holds its value until the next word.
- R7: After lock, hunting stops. A later AA 99 55 66 sequence is packed as ordinary data.
- R8: A valid byte with `in_last` high that arrives before lock, and does not itself complete the pattern, sets `no_sync_err` in the next cycle. The flag stays set until reset. A stream whose last byte completes the pattern raises no error.
- R9: If the last byte of a stream leaves a partial word after lock, that partial word is never emitted and `trunc_err` is set in the next cycle, sticky until reset. A last byte that completes a word emits the word and sets no flag.
- R10: After the byte marked `in_last` has been accepted, all further input is ignored until reset: no lock, no words and no new flags.
- R11: While `in_valid` is low, `in_byte` has no effect on matching or packing.
- R12: `in_last` has no effect while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_last | input | 1 | Marks the current valid byte as the end of the stream |
| sync_found | output | 1 | Pattern seen; packing is active |
| word_data | output | 32 | Most recent packed word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| no_sync_err | output | 1 | Stream ended without the pattern |
| trunc_err | output | 1 | Stream ended part-way through a word |

## Verification
The hardest situations to reach are those where the pattern and the stream boundary interact on a single byte. One is the pattern completing on the byte marked as last. Another is a pattern prefix that restarts inside itself, so that a matcher which simply resets on mismatch would miss it. The stimulus builds these from hand-made sequences, including AA AA 99 55 66, AA 99 AA 99 55 66 and a broken AA 99 55 00 prefix. It also drives pattern bytes, and an end marker, while `in_valid` is low, and keeps sending bytes after a stream has ended. A behavioural model built on byte queues is compared with every output on every clock.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_SYNC_BYTES = 4;
  localparam int unsigned DEF_WORD_BYTES = 4;
  localparam logic [31:0] DEF_SYNC_VALUE = 32'hAA99_5566;

  // byte k of a pattern, counting from the first byte sent
  function automatic logic [7:0] pattern_byte(input logic [31:0] pat, input int unsigned nbytes,
                                              input int unsigned k);
    return pat[(nbytes-1-k)*8 +: 8];
  endfunction
endpackage

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SYNC_BYTES = 4,
  parameter logic [SYNC_BYTES*BYTE_W-1:0] SYNC_VALUE = 32'hAA99_5566
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              done_i,
  output logic              hit_o,
  output logic              locked_o
);
  localparam int unsigned HIST   = SYNC_BYTES - 1;
  localparam int unsigned HIST_W = HIST * BYTE_W;
  localparam int unsigned FILL_W = $clog2(SYNC_BYTES + 1);

  logic [HIST_W-1:0]     hist_q;
  logic [FILL_W-1:0]     fill_q;
  logic                  locked_q;
  logic [SYNC_BYTES-1:0] lane_match;
  logic                  hunt;

  assign hunt = valid_i & ~locked_q & ~done_i;

  // lane 0 is the oldest byte, the last lane is the byte on the input now
  for (genvar i = 0; i < SYNC_BYTES; i++) begin : g_lane
    localparam logic [BYTE_W-1:0] EXP = SYNC_VALUE[(SYNC_BYTES-1-i)*BYTE_W +: BYTE_W];
    if (i < HIST) begin : g_hist
      assign lane_match[i] = (hist_q[(HIST-1-i)*BYTE_W +: BYTE_W] == EXP);
    end else begin : g_now
      assign lane_match[i] = (byte_i == EXP);
    end
  end

  assign hit_o    = hunt & (fill_q == FILL_W'(HIST)) & (&lane_match);
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      fill_q   <= '0;
      locked_q <= 1'b0;
    end else if (hunt) begin
      hist_q <= (hist_q << BYTE_W) | HIST_W'(byte_i);
      if (fill_q != FILL_W'(HIST)) fill_q <= fill_q + 1'b1;
      if (hit_o) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/word_packer.sv
module word_packer #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BYTE_W-1:0]            byte_i,
  input  logic                         take_i,
  output logic [WORD_BYTES*BYTE_W-1:0] word_o,
  output logic                         word_vld_o,
  output logic                         last_slot_o
);
  localparam int unsigned ACC_W = (WORD_BYTES - 1) * BYTE_W;
  localparam int unsigned CNT_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BYTES - 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_slot_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (take_i) begin
        if (cnt_q == LAST) begin
          word_o     <= {acc_q, byte_i};
          word_vld_o <= 1'b1;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        acc_q <= (acc_q << BYTE_W) | ACC_W'(byte_i);
      end
    end
  end
endmodule

// File: rtl/stream_end_monitor.sv
module stream_end_monitor (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic last_i,
  input  logic locked_i,
  input  logic hit_i,
  input  logic last_slot_i,
  output logic done_o,
  output logic no_sync_o,
  output logic trunc_o
);
  logic end_seen;
  assign end_seen = valid_i & last_i & ~done_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      no_sync_o <= 1'b0;
      trunc_o   <= 1'b0;
    end else if (end_seen) begin
      done_o <= 1'b1;
      if (!locked_i && !hit_i) no_sync_o <= 1'b1;
      if (locked_i && !last_slot_i) trunc_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_sync_packer.sv
module cfg_sync_packer #(
  parameter int unsigned BYTE_W     = cfg_sync_pkg::DEF_BYTE_W,
  parameter int unsigned SYNC_BYTES = cfg_sync_pkg::DEF_SYNC_BYTES,
  parameter int unsigned WORD_BYTES = cfg_sync_pkg::DEF_WORD_BYTES,
  parameter logic [SYNC_BYTES*BYTE_W-1:0] SYNC_VALUE = cfg_sync_pkg::DEF_SYNC_VALUE,
  localparam int unsigned WORD_W = WORD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              sync_found,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              no_sync_err,
  output logic              trunc_err
);
  logic hit, locked, done, last_slot, take;

  assign take       = in_valid & locked & ~done;
  assign sync_found = locked;

  sync_hunter #(
    .BYTE_W(BYTE_W), .SYNC_BYTES(SYNC_BYTES), .SYNC_VALUE(SYNC_VALUE)
  ) u_hunter (
    .clk(clk), .rst(rst), .byte_i(in_byte), .valid_i(in_valid), .done_i(done),
    .hit_o(hit), .locked_o(locked)
  );

  word_packer #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)
  ) u_packer (
    .clk(clk), .rst(rst), .byte_i(in_byte), .take_i(take),
    .word_o(word_data), .word_vld_o(word_valid), .last_slot_o(last_slot)
  );

  stream_end_monitor u_end (
    .clk(clk), .rst(rst), .valid_i(in_valid), .last_i(in_last), .locked_i(locked),
    .hit_i(hit), .last_slot_i(last_slot), .done_o(done), .no_sync_o(no_sync_err),
    .trunc_o(trunc_err)
  );
endmodule

// File: rtl/cfg_sync_packer_chk.sv
module cfg_sync_packer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic sync_found,
  input logic word_valid,
  input logic no_sync_err,
  input logic trunc_err
);
  p_sync_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> sync_found);
  p_no_word_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> sync_found);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  p_word_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(in_valid));
  p_nosync_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    no_sync_err |=> no_sync_err);
  p_nosync_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
    no_sync_err |-> !sync_found);
  p_trunc_locked_r9: assert property (@(posedge clk) disable iff (rst)
    trunc_err |-> (sync_found && !word_valid));
  p_idle_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!word_valid && $stable(sync_found)));
  p_single_error_r10: assert property (@(posedge clk) disable iff (rst)
    !(no_sync_err && trunc_err));
endmodule

bind cfg_sync_packer cfg_sync_packer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sync_found(sync_found),
  .word_valid(word_valid), .no_sync_err(no_sync_err), .trunc_err(trunc_err)
);

// File: tb/test_cfg_sync_packer.sv
module test_cfg_sync_packer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        sync_found, word_valid, no_sync_err, trunc_err;
  logic [31:0] word_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_sync_packer i_cfg_sync_packer (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
    .sync_found(sync_found), .word_data(word_data), .word_valid(word_valid),
    .no_sync_err(no_sync_err), .trunc_err(trunc_err)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  m_hist[$];
  logic [7:0]  m_acc[$];
  bit          m_lock, m_done, m_nse, m_tr, m_wv, cmp_en;
  logic [31:0] m_wd;

  always @(posedge clk) begin
    if (rst) begin
      m_hist.delete(); m_acc.delete();
      m_lock = 0; m_done = 0; m_nse = 0; m_tr = 0; m_wv = 0; m_wd = '0;
      cmp_en = 1;
    end else begin
      bit hit;
      hit  = 0;
      m_wv = 0;
      if (in_valid && !m_done) begin
        if (m_lock) begin
          m_acc.push_back(in_byte);
          if (m_acc.size() == 4) begin
            m_wd = {m_acc[0], m_acc[1], m_acc[2], m_acc[3]};
            m_wv = 1;
            m_acc.delete();
          end
        end else begin
          m_hist.push_back(in_byte);
          if (m_hist.size() > 4) void'(m_hist.pop_front());
          if (m_hist.size() == 4 &&
              {m_hist[0], m_hist[1], m_hist[2], m_hist[3]} == 32'hAA995566) hit = 1;
        end
        if (in_last) begin
          m_done = 1;
          if (!m_lock && !hit) m_nse = 1;
          if (m_lock && m_acc.size() != 0) m_tr = 1;
          m_acc.delete();
        end
        if (hit) m_lock = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  int          obs_words;
  logic [31:0] first_wd;

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(sync_found == m_lock, "R2 sync_found", 32'(sync_found), 32'(m_lock));
      chk(word_valid == m_wv, "R6 word_valid", 32'(word_valid), 32'(m_wv));
      chk(word_data == m_wd, "R5 word_data", word_data, m_wd);
      chk(no_sync_err == m_nse, "R8 no_sync_err", 32'(no_sync_err), 32'(m_nse));
      chk(trunc_err == m_tr, "R9 trunc_err", 32'(trunc_err), 32'(m_tr));
      if (word_valid) begin
        if (obs_words == 0) first_wd = word_data;
        obs_words++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_last = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0; obs_words = 0; first_wd = '0;
  endtask

  task automatic send(input logic [7:0] b, input bit last = 0);
    @(negedge clk);
    in_byte = b; in_valid = 1; in_last = last;
  endtask

  task automatic idle(input int n, input logic [7:0] junk = 8'h00, input bit junk_last = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_byte = junk; in_last = junk_last;
    end
  endtask

  task automatic send_word(input logic [31:0] w, input bit last = 0);
    send(w[31:24]); send(w[23:16]); send(w[15:8]); send(w[7:0], last);
  endtask

  task automatic send_preamble();
    send_word(32'hFFFFFFFF); send_word(32'h000000BB); send_word(32'h11220044);
    send_word(32'hFFFFFFFF); send_word(32'hFFFFFFFF);
  endtask

  task automatic finish_case(input string tag, input int exp_words, input bit exp_sync,
                             input bit exp_nse, input bit exp_tr);
    idle(3);
    chk(obs_words == exp_words, {tag, " word count"}, 32'(obs_words), 32'(exp_words));
    chk(sync_found == exp_sync, {tag, " sync_found"}, 32'(sync_found), 32'(exp_sync));
    chk(no_sync_err == exp_nse, {tag, " no_sync_err"}, 32'(no_sync_err), 32'(exp_nse));
    chk(trunc_err == exp_tr, {tag, " trunc_err"}, 32'(trunc_err), 32'(exp_tr));
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(!sync_found && !word_valid && !no_sync_err && !trunc_err && word_data == 0,
        "R1 reset state", {sync_found, word_valid, no_sync_err, trunc_err, word_data[27:0]}, 32'h0);

    // R4/R5/R3: padding, pattern, three words, clean end
    do_reset();
    send_preamble();
    chk(!sync_found, "R3 padding gives no match", 32'(sync_found), 32'h0);
    send_word(32'hAA995566);
    send_word(32'h30000001); send_word(32'h12345678); send_word(32'hDEADBEEF, 1);
    finish_case("R4 preamble", 3, 1, 0, 0);
    chk(first_wd == 32'h30000001, "R5 first word big-endian", first_wd, 32'h30000001);

    // R3/R12: overlapping prefix with gaps; in_last while in_valid low
    do_reset();
    send(8'hAA); idle(2); send(8'hAA); send(8'h99); idle(1); send(8'h55); send(8'h66);
    idle(2, 8'h77, 1);
    send_word(32'hCAFE0001); idle(1, 8'h00, 1); send(8'h42, 1);
    finish_case("R3 overlap/R12 idle last", 1, 1, 0, 1);

    // R3/R9: self-overlapping prefix, two words, partial word at end
    do_reset();
    send(8'hAA); send(8'h99); send_word(32'hAA995566);
    send_word(32'h01020304); send_word(32'h05060708); send(8'h09); send(8'h0A, 1);
    finish_case("R9 truncated", 2, 1, 0, 1);

    // R8/R10: no pattern, then a pattern after the end is ignored
    do_reset();
    send_preamble(); send(8'h5A, 1);
    send_word(32'hAA995566); send_word(32'h11111111);
    finish_case("R8/R10 no sync", 0, 0, 1, 0);

    // R8: pattern completes on the final byte
    do_reset();
    send(8'h00); send(8'hAA); send(8'h99); send(8'h55); send(8'h66, 1);
    send_word(32'h22222222);
    finish_case("R8 sync on last byte", 0, 1, 0, 0);

    // R7: pattern after lock is packed as data
    do_reset();
    send_word(32'hAA995566); send_word(32'hAA995566); send_word(32'h01020304, 1);
    finish_case("R7 no rehunt", 2, 1, 0, 0);
    chk(first_wd == 32'hAA995566, "R7 pattern packed as data", first_wd, 32'hAA995566);

    // R3: broken prefix then real pattern
    do_reset();
    send(8'hAA); send(8'h99); send(8'h55); send(8'h00); send_word(32'hAA995566);
    send_word(32'h0BADF00D, 1);
    finish_case("R3 broken prefix", 1, 1, 0, 0);

    // R11: pattern bytes presented with in_valid low
    do_reset();
    idle(1, 8'hAA); idle(1, 8'h99); idle(1, 8'h55); idle(1, 8'h66);
    send(8'h13, 1);
    finish_case("R11 idle bytes ignored", 0, 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule